// File: doc/BRIEF.md
# Link Self-Test Pattern Checker

This block sits behind a character decoder on the receive side of a serial link. During normal operation it passes the decoded character, the special/data flag and the decoder's violation flag to its outputs, one character per strobe. When the active-low self-test enable is driven low, it switches to checking. It first waits for an initialization character. It then builds the expected test sequence locally and compares each received character with it. Any disagreement raises the violation output for that character time.

The expected sequence loops every 511 characters. It contains a loop marker, a second special character, pseudo-random data from an 8-bit LFSR, and a few positions where the transmitter sends deliberate code violations on purpose. The ready output goes low once the initialization character has arrived. After that it pulses high for one character time per completed loop, so an external counter can track progress. While checking runs, the data outputs carry the expected pattern. A mode output tells the decoder to decode. Self-test forces this output to decoded mode even when bypass is selected.

Top module: `bist_pattern_chk`

## Requirements
- R1: After reset, q_data_o, q_spec_o, viol_o and rdy_o are 0, and the block is in normal (pass-through) operation.
- R2: With bist_en_ni high, a strobe on chr_vld_i loads rx_data_i, rx_spec_i and rx_viol_i into q_data_o, q_spec_o and viol_o on the next clock edge. These values hold until the next strobe. rdy_o is chr_vld_i delayed by one clock.
- R3: One clock after bist_en_ni goes low from normal operation, rdy_o is 1, viol_o is 0, and q_data_o/q_spec_o show the marker 0xBC/1. While waiting, every character other than a violation-free 0xBC with the special flag set is ignored, and the outputs stay as they are.
- R4: When the initialization character (0xBC, special, no violation) is received while waiting, rdy_o falls on the next edge. That character counts as loop position 0, and checking starts with position 1 on the next strobe.
- R5: The expected character at loop position 0 is 0xBC, special. At position 255 it is 0x7C, special. At every other position it is data, with the special flag 0 and the value of the LFSR. The LFSR is 0xFF at position 1 and advances once per position. Each step shifts left and inserts s[7]^s[5]^s[4]^s[3] at bit 0 (x^8+x^6+x^5+x^4+1).
- R6: While checking, each strobe loads the expected character for that position onto q_data_o/q_spec_o, in place of the received one.
- R7: At an ordinary position, viol_o is 1 for the character time if the received data or special flag differs from the expected value, or if rx_viol_i is set. Otherwise it is 0.
- R8: At the deliberate-violation positions 64, 200 and 400, the checker requires rx_viol_i=1 and raises viol_o if it is missing. The received data and flag are not compared there.
- R9: rdy_o is 1 for exactly the character time after position 510 has been checked, which is once per 511 characters. At all other times while checking, rdy_o is 0.
- R10: enc_mode_o equals !bypass_i in normal operation. It is 1 from the clock after bist_en_ni goes low until the block has left self-test.
- R11: When bist_en_ni returns high, the block resumes the pass-through behaviour of R2 from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_vld_i | input | 1 | One-cycle strobe per received character |
| rx_data_i | input | 8 | Decoded character value |
| rx_spec_i | input | 1 | Decoded character is special (1) or data (0) |
| rx_viol_i | input | 1 | Decoder flagged a code violation |
| bist_en_ni | input | 1 | Self-test enable, active low |
| bypass_i | input | 1 | Bypass (undecoded) mode selected |
| q_data_o | output | 8 | Received data, or expected data during self-test |
| q_spec_o | output | 1 | Received or expected special flag |
| viol_o | output | 1 | Violation (normal) or mismatch (self-test) |
| rdy_o | output | 1 | Character ready (normal) or loop pulse (self-test) |
| enc_mode_o | output | 1 | Decoder should decode (1) or bypass (0) |

## Verification
The bench feeds junk characters while the block waits. A checker that starts without the initialization handshake would begin flagging mismatches or drop ready early. It runs whole loops and watches the ready pulse at the wrap. An off-by-one loop counter would move the pulse, or fire it twice. In one loop it corrupts an ordinary data character, omits a deliberate violation and inserts an unexpected one. In another it corrupts data at a deliberate-violation position, where a checker that compares data too eagerly would raise a false mismatch. It also toggles bypass around self-test entry and exit. A mode output that ignores self-test would leave the decoder undecoded during checking.

// File: rtl/bistchk_pkg.sv
`timescale 1ns/1ps
package bistchk_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_WAIT   = 2'd1,
        ST_CHECK  = 2'd2
    } chk_state_e;

    // Fibonacci LFSR step, x^8+x^6+x^5+x^4+1
    function automatic logic [7:0] lfsr8_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction
endpackage

// File: rtl/bist_pattern_gen.sv
`timescale 1ns/1ps
module bist_pattern_gen
    import bistchk_pkg::*;
#(
    parameter int unsigned LOOP_LEN  = 511,
    parameter int unsigned NUM_VIOL  = 3,
    parameter int unsigned VIOL_POS [NUM_VIOL] = '{64, 200, 400},
    parameter int unsigned SPEC_POS  = 255,
    parameter logic [7:0]  MARK_CODE = 8'hBC,
    parameter logic [7:0]  SPEC_CODE = 8'h7C,
    parameter logic [7:0]  SEED      = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       step_i,
    output logic [7:0] exp_data_o,
    output logic       exp_spec_o,
    output logic       exp_viol_o,
    output logic       last_o
);
    localparam int unsigned POSW = $clog2(LOOP_LEN);
    localparam logic [POSW-1:0] LAST_POS = POSW'(LOOP_LEN - 1);

    typedef struct packed {
        logic [POSW-1:0] pos;
        logic [7:0]      lfsr;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [NUM_VIOL-1:0] viol_hit;

    for (genvar i = 0; i < NUM_VIOL; i++) begin : g_viol
        assign viol_hit[i] = (gen_q.pos == POSW'(VIOL_POS[i]));
    end

    always_comb begin
        gen_d = gen_q;
        if (load_i || (step_i && gen_q.pos == '0)) begin
            gen_d.pos  = POSW'(1);
            gen_d.lfsr = SEED;
        end else if (step_i) begin
            gen_d.pos  = (gen_q.pos == LAST_POS) ? '0 : gen_q.pos + POSW'(1);
            gen_d.lfsr = lfsr8_next(gen_q.lfsr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '{pos: '0, lfsr: SEED};
        end else begin
            gen_q <= gen_d;
        end
    end

    always_comb begin
        if (gen_q.pos == '0) begin
            exp_data_o = MARK_CODE;
            exp_spec_o = 1'b1;
        end else if (gen_q.pos == POSW'(SPEC_POS)) begin
            exp_data_o = SPEC_CODE;
            exp_spec_o = 1'b1;
        end else begin
            exp_data_o = gen_q.lfsr;
            exp_spec_o = 1'b0;
        end
        exp_viol_o = |viol_hit;
        last_o     = (gen_q.pos == LAST_POS);
    end

    // R9
    wrap_to_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && last_o) |=> (exp_data_o == MARK_CODE && exp_spec_o));
endmodule

// File: rtl/bist_char_cmp.sv
`timescale 1ns/1ps
module bist_char_cmp #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] rx_data_i,
    input  logic          rx_spec_i,
    input  logic          rx_viol_i,
    input  logic [DW-1:0] exp_data_i,
    input  logic          exp_spec_i,
    input  logic          exp_viol_i,
    output logic          mismatch_o
);
    always_comb begin
        if (exp_viol_i) begin
            mismatch_o = !rx_viol_i;
        end else begin
            mismatch_o = rx_viol_i || (rx_data_i != exp_data_i) || (rx_spec_i != exp_spec_i);
        end
    end
endmodule

// File: rtl/bist_pattern_chk.sv
`timescale 1ns/1ps
module bist_pattern_chk
    import bistchk_pkg::*;
#(
    parameter int unsigned LOOP_LEN  = 511,
    parameter int unsigned NUM_VIOL  = 3,
    parameter int unsigned VIOL_POS [NUM_VIOL] = '{64, 200, 400},
    parameter int unsigned SPEC_POS  = 255,
    parameter logic [7:0]  MARK_CODE = 8'hBC,
    parameter logic [7:0]  SPEC_CODE = 8'h7C,
    parameter logic [7:0]  SEED      = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chr_vld_i,
    input  logic [7:0] rx_data_i,
    input  logic       rx_spec_i,
    input  logic       rx_viol_i,
    input  logic       bist_en_ni,
    input  logic       bypass_i,
    output logic [7:0] q_data_o,
    output logic       q_spec_o,
    output logic       viol_o,
    output logic       rdy_o,
    output logic       enc_mode_o
);
    typedef struct packed {
        chk_state_e state;
        logic [7:0] data;
        logic       spec;
        logic       viol;
        logic       rdy;
    } top_t;

    top_t st_d, st_q;
    logic       gen_load, gen_step;
    logic [7:0] exp_data;
    logic       exp_spec, exp_viol, gen_last, mismatch;
    logic       init_seen;

    bist_pattern_gen #(
        .LOOP_LEN (LOOP_LEN),
        .NUM_VIOL (NUM_VIOL),
        .VIOL_POS (VIOL_POS),
        .SPEC_POS (SPEC_POS),
        .MARK_CODE(MARK_CODE),
        .SPEC_CODE(SPEC_CODE),
        .SEED     (SEED)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (gen_load),
        .step_i    (gen_step),
        .exp_data_o(exp_data),
        .exp_spec_o(exp_spec),
        .exp_viol_o(exp_viol),
        .last_o    (gen_last)
    );

    bist_char_cmp #(.DW(8)) u_cmp (
        .rx_data_i (rx_data_i),
        .rx_spec_i (rx_spec_i),
        .rx_viol_i (rx_viol_i),
        .exp_data_i(exp_data),
        .exp_spec_i(exp_spec),
        .exp_viol_i(exp_viol),
        .mismatch_o(mismatch)
    );

    assign init_seen = chr_vld_i && rx_spec_i && !rx_viol_i && (rx_data_i == MARK_CODE);

    always_comb begin
        st_d     = st_q;
        gen_load = 1'b0;
        gen_step = 1'b0;
        if (bist_en_ni) begin
            st_d.state = ST_NORMAL;
            st_d.rdy   = chr_vld_i;
            if (chr_vld_i) begin
                st_d.data = rx_data_i;
                st_d.spec = rx_spec_i;
                st_d.viol = rx_viol_i;
            end
        end else begin
            unique case (st_q.state)
                ST_NORMAL: begin
                    st_d.state = ST_WAIT;
                    st_d.rdy   = 1'b1;
                    st_d.viol  = 1'b0;
                    st_d.data  = MARK_CODE;
                    st_d.spec  = 1'b1;
                end
                ST_WAIT: begin
                    if (init_seen) begin
                        st_d.state = ST_CHECK;
                        st_d.rdy   = 1'b0;
                        st_d.viol  = 1'b0;
                        gen_load   = 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (chr_vld_i) begin
                        gen_step  = 1'b1;
                        st_d.data = exp_data;
                        st_d.spec = exp_spec;
                        st_d.viol = mismatch;
                        st_d.rdy  = gen_last;
                    end
                end
                default: st_d.state = ST_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_NORMAL, data: '0, spec: 1'b0, viol: 1'b0, rdy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_data_o   = st_q.data;
    assign q_spec_o   = st_q.spec;
    assign viol_o     = st_q.viol;
    assign rdy_o      = st_q.rdy;
    assign enc_mode_o = !bypass_i || (st_q.state != ST_NORMAL);

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_en_ni && chr_vld_i) |=> (q_data_o == $past(rx_data_i) && viol_o == $past(rx_viol_i) && rdy_o));

    // R10
    force_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bist_en_ni |=> enc_mode_o);

    // R3
    wait_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_WAIT) |-> (rdy_o && !viol_o));

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_CHECK && !bist_en_ni && rdy_o && chr_vld_i) |=> !rdy_o);

    // R7
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_CHECK && !bist_en_ni && !chr_vld_i) |=> ($stable(viol_o) && $stable(rdy_o) && $stable(q_data_o)));
endmodule

// File: tb/bist_pattern_chk_tb.sv
`timescale 1ns/1ps
module bist_pattern_chk_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chr_vld_i = 1'b0;
    logic [7:0] rx_data_i = '0;
    logic       rx_spec_i = 1'b0;
    logic       rx_viol_i = 1'b0;
    logic       bist_en_ni = 1'b1;
    logic       bypass_i = 1'b0;
    logic [7:0] q_data_o;
    logic       q_spec_o, viol_o, rdy_o, enc_mode_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] tb_lfsr = 8'hFF;

    always #2 clk = ~clk;

    bist_pattern_chk u_dut (
        .clk(clk), .rst_n(rst_n), .chr_vld_i(chr_vld_i), .rx_data_i(rx_data_i),
        .rx_spec_i(rx_spec_i), .rx_viol_i(rx_viol_i), .bist_en_ni(bist_en_ni),
        .bypass_i(bypass_i), .q_data_o(q_data_o), .q_spec_o(q_spec_o),
        .viol_o(viol_o), .rdy_o(rdy_o), .enc_mode_o(enc_mode_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] d, input logic s, input logic v);
        @(negedge clk);
        chr_vld_i = 1'b1; rx_data_i = d; rx_spec_i = s; rx_viol_i = v;
        @(negedge clk);
        chr_vld_i = 1'b0;
    endtask

    function automatic logic [7:0] lfsr_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic bit is_vpos(input int p);
        return (p == 64) || (p == 200) || (p == 400);
    endfunction

    task automatic t_reset();
        chk("R1 q_data", q_data_o, 0);
        chk("R1 viol", viol_o, 0);
        chk("R1 rdy", rdy_o, 0);
        chk("R1 enc_mode", enc_mode_o, 1);
    endtask

    task automatic t_normal();
        send_char(8'h5A, 1'b0, 1'b1);
        chk("R2 data", q_data_o, 8'h5A);
        chk("R2 viol", viol_o, 1);
        chk("R2 rdy", rdy_o, 1);
        @(negedge clk);
        chk("R2 rdy idle", rdy_o, 0);
        chk("R2 hold", q_data_o, 8'h5A);
        send_char(8'h3C, 1'b1, 1'b0);
        chk("R2 spec", q_spec_o, 1);
        chk("R2 viol clr", viol_o, 0);
    endtask

    task automatic t_enter();
        bypass_i = 1'b1;
        @(negedge clk);
        chk("R10 bypass", enc_mode_o, 0);
        bist_en_ni = 1'b0;
        @(negedge clk);
        chk("R10 forced", enc_mode_o, 1);
        chk("R3 rdy", rdy_o, 1);
        chk("R3 viol", viol_o, 0);
        chk("R3 marker", {q_spec_o, q_data_o}, {1'b1, 8'hBC});
        send_char(8'h12, 1'b0, 1'b0);
        send_char(8'hBC, 1'b0, 1'b0);
        send_char(8'hBC, 1'b1, 1'b1);
        chk("R3 ignore rdy", rdy_o, 1);
        chk("R3 ignore viol", viol_o, 0);
        chk("R3 ignore data", q_data_o, 8'hBC);
        send_char(8'hBC, 1'b1, 1'b0);
        chk("R4 rdy low", rdy_o, 0);
        chk("R4 viol", viol_o, 0);
    endtask

    // positions 1..510 then 0; negative index disables an injection
    task automatic t_loop(input int bad, input int miss, input int extra);
        for (int k = 1; k <= 511; k++) begin
            int p;
            logic [7:0] ed;
            logic es, rv, ev;
            logic [7:0] sd;
            p = (k == 511) ? 0 : k;
            if (p == 1) tb_lfsr = 8'hFF;
            else if (p > 1) tb_lfsr = lfsr_step(tb_lfsr);
            if (p == 0) begin ed = 8'hBC; es = 1'b1; end
            else if (p == 255) begin ed = 8'h7C; es = 1'b1; end
            else begin ed = tb_lfsr; es = 1'b0; end
            sd = (p == bad) ? (ed ^ 8'h01) : ed;
            if (is_vpos(p)) begin
                rv = (p != miss);
                ev = (p == miss);
            end else begin
                rv = (p == extra);
                ev = (p == extra) || (p == bad);
            end
            send_char(sd, es, rv);
            chk("R5/R6 expected data", {q_spec_o, q_data_o}, {es, ed});
            chk("R7/R8 viol", viol_o, ev);
            chk("R9 rdy", rdy_o, (p == 510));
        end
    endtask

    task automatic t_exit();
        bist_en_ni = 1'b1;
        @(negedge clk);
        chk("R10 back to bypass", enc_mode_o, 0);
        send_char(8'hA7, 1'b0, 1'b0);
        chk("R11 data", q_data_o, 8'hA7);
        chk("R11 spec", q_spec_o, 0);
        chk("R11 rdy", rdy_o, 1);
        bypass_i = 1'b0;
        @(negedge clk);
        chk("R10 decode", enc_mode_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_normal();
        t_enter();
        t_loop(-1, -1, -1);
        t_loop(5, 64, 10);
        t_loop(200, -1, -1);
        t_exit();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule